// File: doc/BRIEF.md
# Hot Swap Sequencing Controller

This block decides when the gate driver of a series power MOSFET may conduct, on a board that is plugged into a live supply. Threshold comparators outside the block report the analog state. They flag source and load over- or under-voltage, whether the load has come within a few percent of the source, a coarse level of the load voltage, and the sensed current against a ladder of thresholds. A separate comparator flags the breaker limit, and a fast digital input flags a short. The block never sees a voltage or current value, only these flags.

After the board is seen and the source has stayed healthy for a debounce span, the switch is turned on. Inrush is then limited by switching the gate bang-bang between two current thresholds. The pair of thresholds is picked from the current load-voltage band, so that a large drain-source voltage is paired with a small current. Once the load has caught up with the source, the switch stays fully on. Any protection event latches the switch off and records its causes. A remote or manual power-down request isolates the board.

Top module: `hot_swap_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `gate_en` and `power_good` are 0 and `fault_cause` is 0. The state codes are: idle 0, debounce 1, inrush 2, on 3, fault 4, off-request 5.
- R2: From idle, the block enters debounce when the board is present, the source is inside its limits and no power-down is asked. It enters inrush only after exactly `DEB_CYC` consecutive qualifying cycles in debounce. A cycle that fails to qualify returns the block to idle and restarts the count.
- R3: In inrush the gate starts on. It turns off the cycle after the upper flag of the active band is set, and turns on the cycle after the lower flag is clear. Between the two it holds its value.
- R4: `cur_gt[i]` is set when the current exceeds threshold i, and the thresholds rise with i. Band k uses `cur_gt[k+1]` as its upper flag and `cur_gt[k]` as its lower flag. The band is `load_lvl`, and any value of `NUM_BANDS` or more selects the top band.
- R5: In inrush, `load_near_src` moves the block to on, where `gate_en` and `power_good` are 1. It takes precedence over the inrush timeout.
- R6: After `INRUSH_CYC` cycles in inrush without `load_near_src`, the block enters fault with `fault_cause` bit 6 (timeout).
- R7: `cur_oc` in inrush or on causes fault with bit 0 set, and the gate is off from the next cycle.
- R8: `fast_oc` drives `gate_en` low in the same cycle in every state. In inrush or on it causes fault with bit 1 set.
- R9: In inrush or on, `src_ov` causes fault with bit 2, `src_uv` with bit 3 and `load_ov` with bit 4. `load_uv` causes fault with bit 5 only in on; it is ignored during inrush.
- R10: `pd_remote` or `pd_manual` in inrush or on moves the block to off-request with the gate off. The block returns to idle once both are low. Idle does not start debounce while either is high. The gate is only ever on in inrush or on.
- R11: Fault keeps `fault_cause` unchanged and non-zero. It returns to idle, clearing `fault_cause`, only when the over-current, short, source over/under-voltage and load over-voltage flags are all low and, in the same cycle, `board_present` rises or the OR of the two power-down inputs changes.
- R12: Removing the board in inrush or on returns the block to idle with the gate off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| board_present | input | 1 | Board is seated |
| pd_remote | input | 1 | Power-down request from the backplane |
| pd_manual | input | 1 | Power-down request from the on-board switch |
| src_ov | input | 1 | Source above its upper limit |
| src_uv | input | 1 | Source below its lower limit |
| load_ov | input | 1 | Load above its upper limit |
| load_uv | input | 1 | Load below its lower limit |
| load_near_src | input | 1 | Load within 5% of source |
| load_lvl | input | LVL_W | Load-voltage band, 0 = lowest |
| cur_gt | input | NUM_BANDS+1 | Current above each inrush threshold (thermometer) |
| cur_oc | input | 1 | Current above the breaker limit |
| fast_oc | input | 1 | Fast short-circuit flag |
| gate_en | output | 1 | Gate driver enable |
| power_good | output | 1 | Switch fully on |
| state_o | output | 3 | Controller state code |
| fault_cause | output | 7 | Latched trip causes |

## Verification
The assertions check on every cycle the properties that hold whatever the stimulus. A short always masks the gate in the same cycle. The gate conducts only in inrush or on. A breaker trip from on lands in fault with its cause bit set. Causes are non-zero and frozen while in fault and zero in idle. All-flags-set current forces the gate off in inrush, and debounce lasts exactly its span before inrush. The bench scenarios show what needs a planned sequence of inputs:
- the hysteresis hold between the two thresholds for every band, including the clamped band code;
- the debounce restart;
- the timeout length;
- each trip cause taken on its own;
- `load_uv` being ignored during inrush;
- the re-arm conditions that let fault return to idle.

// File: rtl/hsc_pkg.sv
// Shared encodings of the hot swap controller: state codes and the
// positions of the latched trip-cause bits.
package hsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DEBOUNCE = 3'd1,
        ST_INRUSH  = 3'd2,
        ST_ON      = 3'd3,
        ST_FAULT   = 3'd4,
        ST_OFFREQ  = 3'd5
    } hsc_state_e;

    localparam int unsigned FC_N      = 7;
    localparam int unsigned FC_OC     = 0;
    localparam int unsigned FC_SHORT  = 1;
    localparam int unsigned FC_SRC_OV = 2;
    localparam int unsigned FC_SRC_UV = 3;
    localparam int unsigned FC_LD_OV  = 4;
    localparam int unsigned FC_LD_UV  = 5;
    localparam int unsigned FC_TMO    = 6;

endpackage

// File: rtl/hsc_span_timer.sv
// Qualified span counter: counts consecutive cycles with run high and
// pulses done in the LIMIT-th such cycle. Any cycle with run low, or the
// done cycle itself, restarts the count. Assumes LIMIT >= 1.
module hsc_span_timer #(
    parameter int unsigned LIMIT = 4,
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    logic [W-1:0] cnt_q;

    assign done = run && (cnt_q == W'(LIMIT - 1));

    // count qualifying cycles, restarting on a gap or on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hsc_inrush_gate.sv
// Band-dependent hysteretic gate decision for inrush. It selects the
// threshold pair from the load-voltage band (clamped to the top band) and
// returns the gate value for the next cycle. Assumes cur_gt is a
// thermometer code of ascending current thresholds.
module hsc_inrush_gate #(
    parameter int unsigned NUM_BANDS = 4,
    localparam int unsigned LVL_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1
) (
    input  logic [LVL_W-1:0]   load_lvl,
    input  logic [NUM_BANDS:0] cur_gt,
    input  logic               gate_now,
    output logic               gate_next
);

    logic upper_hit;
    logic lower_hit;

    // pick the upper and lower current flags for the active band
    always_comb begin
        upper_hit = cur_gt[NUM_BANDS];
        lower_hit = cur_gt[NUM_BANDS-1];
        for (int k = 0; k < NUM_BANDS - 1; k++) begin
            if ({1'b0, load_lvl} == (LVL_W + 1)'(k)) begin
                upper_hit = cur_gt[k+1];
                lower_hit = cur_gt[k];
            end
        end
    end

    // bang-bang decision with hold between the two thresholds
    always_comb begin
        if (upper_hit) begin
            gate_next = 1'b0;
        end else if (!lower_hit) begin
            gate_next = 1'b1;
        end else begin
            gate_next = gate_now;
        end
    end

endmodule

// File: rtl/hsc_trip_detect.sv
// Trip classifier: maps the protection flags onto cause bits, gated by the
// states in which each flag counts. Load under-voltage counts only once
// fully on, and the timeout only when the load has not caught up.
module hsc_trip_detect
    import hsc_pkg::*;
(
    input  hsc_state_e       state,
    input  logic             cur_oc,
    input  logic             fast_oc,
    input  logic             src_ov,
    input  logic             src_uv,
    input  logic             load_ov,
    input  logic             load_uv,
    input  logic             load_near_src,
    input  logic             inrush_done,
    output logic [FC_N-1:0]  trip
);

    logic live;
    assign live = (state == ST_INRUSH) || (state == ST_ON);

    // classify every active protection condition
    always_comb begin
        trip            = '0;
        trip[FC_OC]     = live && cur_oc;
        trip[FC_SHORT]  = live && fast_oc;
        trip[FC_SRC_OV] = live && src_ov;
        trip[FC_SRC_UV] = live && src_uv;
        trip[FC_LD_OV]  = live && load_ov;
        trip[FC_LD_UV]  = (state == ST_ON) && load_uv;
        trip[FC_TMO]    = (state == ST_INRUSH) && inrush_done && !load_near_src;
    end

endmodule

// File: rtl/hot_swap_ctrl.sv
// Hot swap sequencing controller. It sequences idle, debounce, inrush and
// on, trips into a latched fault, and honours power-down requests. It
// assumes all inputs are synchronous to clk and that the analog thresholds
// are applied by external comparators.
module hot_swap_ctrl
    import hsc_pkg::*;
#(
    parameter int unsigned DEB_CYC    = 1500000,
    parameter int unsigned INRUSH_CYC = 500000,
    parameter int unsigned NUM_BANDS  = 4,
    localparam int unsigned LVL_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               board_present,
    input  logic               pd_remote,
    input  logic               pd_manual,
    input  logic               src_ov,
    input  logic               src_uv,
    input  logic               load_ov,
    input  logic               load_uv,
    input  logic               load_near_src,
    input  logic [LVL_W-1:0]   load_lvl,
    input  logic [NUM_BANDS:0] cur_gt,
    input  logic               cur_oc,
    input  logic               fast_oc,
    output logic               gate_en,
    output logic               power_good,
    output logic [2:0]         state_o,
    output logic [FC_N-1:0]    fault_cause
);

    hsc_state_e      state_q, state_d;
    logic            gate_q, gate_d;
    logic            bp_q, pd_q;
    logic [FC_N-1:0] cause_q;
    logic [FC_N-1:0] trip;
    logic            pd_any, src_ok, deb_qual;
    logic            deb_done, inrush_done;
    logic            hyst_gate, rearm, fault_clear;

    assign pd_any      = pd_remote || pd_manual;
    assign src_ok      = !src_ov && !src_uv;
    assign deb_qual    = board_present && src_ok && !pd_any;
    assign rearm       = (board_present && !bp_q) || (pd_any != pd_q);
    assign fault_clear = !(cur_oc || fast_oc || src_ov || src_uv || load_ov);

    hsc_span_timer #(.LIMIT(DEB_CYC)) u_deb_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state_q == ST_DEBOUNCE) && deb_qual),
        .done  (deb_done)
    );

    hsc_span_timer #(.LIMIT(INRUSH_CYC)) u_inrush_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_INRUSH),
        .done  (inrush_done)
    );

    hsc_inrush_gate #(.NUM_BANDS(NUM_BANDS)) u_gate (
        .load_lvl  (load_lvl),
        .cur_gt    (cur_gt),
        .gate_now  (gate_q),
        .gate_next (hyst_gate)
    );

    hsc_trip_detect u_trip (
        .state         (state_q),
        .cur_oc        (cur_oc),
        .fast_oc       (fast_oc),
        .src_ov        (src_ov),
        .src_uv        (src_uv),
        .load_ov       (load_ov),
        .load_uv       (load_uv),
        .load_near_src (load_near_src),
        .inrush_done   (inrush_done),
        .trip          (trip)
    );

    // next-state selection; trips outrank requests, which outrank removal
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (deb_qual) state_d = ST_DEBOUNCE;
            ST_DEBOUNCE: begin
                if (!deb_qual)     state_d = ST_IDLE;
                else if (deb_done) state_d = ST_INRUSH;
            end
            ST_INRUSH, ST_ON: begin
                if (|trip)               state_d = ST_FAULT;
                else if (pd_any)         state_d = ST_OFFREQ;
                else if (!board_present) state_d = ST_IDLE;
                else if (state_q == ST_INRUSH && load_near_src) state_d = ST_ON;
            end
            ST_FAULT:    if (fault_clear && rearm) state_d = ST_IDLE;
            ST_OFFREQ:   if (!pd_any) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // gate for the next cycle: hysteresis in inrush, solid on, else off
    always_comb begin
        case (state_d)
            ST_INRUSH: gate_d = (state_q == ST_INRUSH) ? hyst_gate : 1'b1;
            ST_ON:     gate_d = 1'b1;
            default:   gate_d = 1'b0;
        endcase
    end

    // state, gate and edge-detect registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gate_q  <= 1'b0;
            bp_q    <= 1'b0;
            pd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            gate_q  <= gate_d;
            bp_q    <= board_present;
            pd_q    <= pd_any;
        end
    end

    // latch trip causes until the fault is re-armed back to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (state_q == ST_FAULT && state_d == ST_IDLE) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_q | trip;
        end
    end

    assign gate_en     = gate_q && !fast_oc;
    assign power_good  = (state_q == ST_ON);
    assign state_o     = state_q;
    assign fault_cause = cause_q;

endmodule

// File: rtl/hsc_checker.sv
// Protocol checker for hot_swap_ctrl, attached with bind. It watches the
// ports only and tracks the length of each debounce run with its own
// counter.
module hsc_checker
    import hsc_pkg::*;
#(
    parameter int unsigned DEB_CYC   = 4,
    parameter int unsigned NUM_BANDS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         state_o,
    input logic               gate_en,
    input logic               power_good,
    input logic [FC_N-1:0]    fault_cause,
    input logic               fast_oc,
    input logic               cur_oc,
    input logic               load_near_src,
    input logic [NUM_BANDS:0] cur_gt
);

    logic [31:0] deb_run_q;
    logic [2:0]  prev_state_q;

    // measure consecutive debounce cycles and remember the last state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deb_run_q    <= '0;
            prev_state_q <= 3'(ST_IDLE);
        end else begin
            deb_run_q    <= (state_o == 3'(ST_DEBOUNCE)) ? deb_run_q + 1 : '0;
            prev_state_q <= state_o;
        end
    end

    p_short_masks_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fast_oc |-> !gate_en);

    p_gate_only_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (state_o == 3'(ST_INRUSH) || state_o == 3'(ST_ON)));

    p_breaker_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_ON) && cur_oc) |=>
            (state_o == 3'(ST_FAULT) && fault_cause[FC_OC] && !gate_en));

    p_cause_set_in_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_FAULT)) |-> (fault_cause != '0));

    p_cause_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_FAULT) ##1 state_o == 3'(ST_FAULT)) |-> $stable(fault_cause));

    p_idle_cause_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_IDLE)) |-> (fault_cause == '0));

    p_pg_from_inrush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (power_good && prev_state_q != 3'(ST_ON)) |-> (prev_state_q == 3'(ST_INRUSH)));

    p_full_current_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_INRUSH) && (&cur_gt) && !load_near_src) |=> !gate_en);

    p_debounce_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_INRUSH) && prev_state_q == 3'(ST_DEBOUNCE)) |->
            (deb_run_q == DEB_CYC));

endmodule

bind hot_swap_ctrl hsc_checker #(
    .DEB_CYC   (DEB_CYC),
    .NUM_BANDS (NUM_BANDS)
) u_hsc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_o       (state_o),
    .gate_en       (gate_en),
    .power_good    (power_good),
    .fault_cause   (fault_cause),
    .fast_oc       (fast_oc),
    .cur_oc        (cur_oc),
    .load_near_src (load_near_src),
    .cur_gt        (cur_gt)
);

// File: tb/tb_hot_swap_ctrl.sv
// Scenario bench for hot_swap_ctrl with short spans and three bands.
// Inputs are driven at the falling edge and outputs are checked there.
module tb_hot_swap_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;
    localparam int INR        = 40;
    localparam int NB         = 3;
    localparam int LW         = (NB > 1) ? $clog2(NB) : 1;

    localparam int S_IDLE = 0, S_DEB = 1, S_INR = 2, S_ON = 3, S_FLT = 4, S_OFF = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          board_present, pd_remote, pd_manual;
    logic          src_ov, src_uv, load_ov, load_uv, load_near_src;
    logic [LW-1:0] load_lvl;
    logic [NB:0]   cur_gt;
    logic          cur_oc, fast_oc;
    logic          gate_en, power_good;
    logic [2:0]    state_o;
    logic [6:0]    fault_cause;

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hot_swap_ctrl #(
        .DEB_CYC    (DEB),
        .INRUSH_CYC (INR),
        .NUM_BANDS  (NB)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .board_present (board_present),
        .pd_remote     (pd_remote),
        .pd_manual     (pd_manual),
        .src_ov        (src_ov),
        .src_uv        (src_uv),
        .load_ov       (load_ov),
        .load_uv       (load_uv),
        .load_near_src (load_near_src),
        .load_lvl      (load_lvl),
        .cur_gt        (cur_gt),
        .cur_oc        (cur_oc),
        .fast_oc       (fast_oc),
        .gate_en       (gate_en),
        .power_good    (power_good),
        .state_o       (state_o),
        .fault_cause   (fault_cause)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        board_present = 0; pd_remote = 0; pd_manual = 0;
        src_ov = 0; src_uv = 0; load_ov = 0; load_uv = 0;
        load_near_src = 0; load_lvl = '0; cur_gt = '0;
        cur_oc = 0; fast_oc = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        clear_inputs();
        step(2);
        rst_n = 1;
    endtask

    // reset, then debounce into inrush
    task automatic to_inrush();
        do_reset();
        board_present = 1;
        step(DEB + 1);
    endtask

    task automatic to_on();
        to_inrush();
        load_near_src = 1;
        step(1);
    endtask

    initial begin
        clear_inputs();
        @(negedge clk);

        // R1: reset values
        rst_n = 0;
        step(2);
        chk("R1 state", state_o, S_IDLE);
        chk("R1 gate", gate_en, 0);
        chk("R1 pg", power_good, 0);
        chk("R1 cause", fault_cause, 0);
        rst_n = 1;

        // R2: sweep how long the board is held before removal
        for (int k = 1; k <= DEB + 2; k++) begin
            do_reset();
            board_present = 1;
            step(k);
            chk("R2 debounce length", state_o, (k >= DEB + 1) ? S_INR : S_DEB);
            board_present = 0;
            step(1);
            chk("R2/R12 drop to idle", state_o, S_IDLE);
        end

        // R2: a source glitch restarts the debounce count
        do_reset();
        board_present = 1;
        step(DEB);
        src_uv = 1;
        step(1);
        chk("R2 glitch to idle", state_o, S_IDLE);
        src_uv = 0;
        step(DEB);
        chk("R2 restarted count", state_o, S_DEB);
        step(1);
        chk("R2 inrush after full span", state_o, S_INR);
        chk("R3 gate starts on", gate_en, 1);

        // R3/R4: hysteresis for every band code, including a clamped one
        for (int lvl = 0; lvl < (1 << LW); lvl++) begin
            automatic int band = (lvl >= NB) ? NB - 1 : lvl;
            automatic bit exp_gate = 1;
            to_inrush();
            load_lvl = LW'(lvl);
            for (int s = 0; s < 2 * (NB + 1) + 1; s++) begin
                automatic int c = (s <= NB + 1) ? s : 2 * (NB + 1) - s;
                cur_gt = (NB + 1)'((1 << c) - 1);
                step(1);
                if (c >= band + 2)      exp_gate = 0;
                else if (c <= band)     exp_gate = 1;
                chk((lvl >= NB) ? "R4 clamped band gate" : "R3 hysteresis gate",
                    gate_en, exp_gate);
            end
            chk("R3 still inrush", state_o, S_INR);
        end

        // R5: load catches up, switch fully on
        to_on();
        chk("R5 state on", state_o, S_ON);
        chk("R5 pg", power_good, 1);
        chk("R5 gate", gate_en, 1);

        // R9: load_uv ignored during inrush
        to_inrush();
        load_uv = 1;
        step(2);
        chk("R9 load_uv ignored in inrush", state_o, S_INR);
        chk("R9 cause untouched", fault_cause, 0);

        // R6/R11: timeout, then the re-arm rules
        to_inrush();
        step(INR - 1);
        chk("R6 before timeout", state_o, S_INR);
        step(1);
        chk("R6 timeout fault", state_o, S_FLT);
        chk("R6 timeout cause", fault_cause, 1 << 6);
        chk("R6 gate off", gate_en, 0);
        step(5);
        chk("R11 fault holds", state_o, S_FLT);
        board_present = 0;
        step(1);
        chk("R11 removal is no re-arm", state_o, S_FLT);
        src_uv = 1;
        board_present = 1;
        step(1);
        chk("R11 not cleared blocks exit", state_o, S_FLT);
        chk("R11 cause kept", fault_cause, 1 << 6);
        src_uv = 0;
        step(1);
        chk("R11 needs new event", state_o, S_FLT);
        board_present = 0;
        step(1);
        board_present = 1;
        step(1);
        chk("R11 re-armed to idle", state_o, S_IDLE);
        chk("R11 cause cleared", fault_cause, 0);
        step(1);
        chk("R11 new debounce", state_o, S_DEB);

        // R7/R8/R9: each trip source taken on its own from the on state
        for (int f = 0; f < 6; f++) begin
            to_on();
            case (f)
                0: cur_oc  = 1;
                1: fast_oc = 1;
                2: src_ov  = 1;
                3: src_uv  = 1;
                4: load_ov = 1;
                default: load_uv = 1;
            endcase
            #1;
            if (f == 1) chk("R8 same-cycle gate off", gate_en, 0);
            step(1);
            chk((f == 0) ? "R7 trip state" : (f == 1) ? "R8 trip state" : "R9 trip state",
                state_o, S_FLT);
            chk((f == 0) ? "R7 cause" : (f == 1) ? "R8 cause" : "R9 cause",
                fault_cause, 1 << f);
            chk("R7 gate off after trip", gate_en, 0);
            cur_oc = 0; fast_oc = 0; src_ov = 0; src_uv = 0; load_ov = 0; load_uv = 0;
            pd_manual = 1;
            step(1);
            chk("R11 pd toggle re-arm", state_o, S_IDLE);
            chk("R11 cause cleared by pd", fault_cause, 0);
        end

        // R8: short input masks gate in inrush as well
        to_inrush();
        fast_oc = 1;
        #1;
        chk("R8 inrush gate masked", gate_en, 0);
        step(1);
        chk("R8 inrush short cause", fault_cause, 1 << 1);

        // R10: power-down requests
        to_on();
        pd_remote = 1;
        step(1);
        chk("R10 off request", state_o, S_OFF);
        chk("R10 gate off", gate_en, 0);
        chk("R10 pg off", power_good, 0);
        step(3);
        chk("R10 held while requested", state_o, S_OFF);
        pd_remote = 0;
        step(1);
        chk("R10 back to idle", state_o, S_IDLE);
        pd_manual = 1;
        step(3);
        chk("R10 idle blocked by request", state_o, S_IDLE);
        pd_manual = 0;
        step(1);
        chk("R10 debounce after release", state_o, S_DEB);

        // R12: board removal while on
        to_on();
        board_present = 0;
        step(1);
        chk("R12 removal to idle", state_o, S_IDLE);
        chk("R12 gate off", gate_en, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule